// File: doc/BRIEF.md
# Mode-Selectable Inverting Bus Transceiver

This block is a nine-bit, two-way transfer stage between a local tri-state port (side A) and a shared open-drain, wired-OR backplane port (side B). Each direction has its own data element. That element can be a straight pass-through, a level-sensitive hold stage, or an edge-capture stage. One two-bit select input chooses the element for both directions at once, and one of its codes gives the two directions different element types. Every path inverts its data between input and output.

The two per-direction strobe inputs are sampled on the system clock. An edge-capture stage takes its input on the first clock at which its strobe is seen high after being low. A hold stage follows its input while its strobe is low and freezes while the strobe is high. The A side has one output-enable term. The B side never drives a high level: for each bit it either asserts a pull-low enable for the pad or leaves the line to the pull-up. It does so under a pair of enables and a power-good qualifier. The stored values keep updating, or are kept, whatever the state of the output enables.

Top module: `bus_xcvr_core`

## Requirements
- R1: With `mode_sel` = 2'b00 (bit 0 is the low select, bit 1 the high select), both directions are hold stages.
- R2: With `mode_sel` = 2'b01 (bit 0 = 1, bit 1 = 0), both directions are pass-through, and a change at the input shows at the output with no clock edge.
- R3: With `mode_sel` = 2'b10, both directions are edge-capture stages.
- R4: With `mode_sel` = 2'b11, the A-to-B direction is an edge-capture stage and the B-to-A direction is a hold stage.
- R5: An edge-capture stage loads its input on the clock edge at which its strobe is sampled high after being sampled low on the edge before. It keeps that value while the strobe stays high, stays low, or falls.
- R6: A hold stage is transparent while its strobe is low. While the strobe is high it holds the input value sampled on the last clock edge at which the strobe was low.
- R7: Every output bit is the inverse of its input bit, or of the stored bit, in every mode.
- R8: `a_oe` equals `a_en`. The A outputs are meant to be driven only while it is 1.
- R9: The B side is active only when `b_en_hi` is 1 and `b_en_lo` is 0. In every other combination all `b_pull_low` bits are 0.
- R10: While the B side is active, `b_pull_low[i]` is 1 exactly when the inverted A-to-B output bit i is 0, that is, when the A-side data bit is 1.
- R11: The stages load and keep data while `a_en` is 0 or the B side is inactive. The stored value appears once the outputs are enabled.
- R12: While `power_good` is 0, all `b_pull_low` bits are 0, whatever the other enables are.
- R13: After reset, both stored values are zero, so every edge-capture output reads all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples strobes and updates storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Element-type select for both directions |
| cap_ab | input | 1 | A-to-B strobe: capture edge or hold enable (hold when high) |
| cap_ba | input | 1 | B-to-A strobe: capture edge or hold enable (hold when high) |
| a_in | input | 9 | Data received from the A side pads |
| a_out | output | 9 | Data to drive onto the A side pads |
| a_en | input | 1 | A-side output enable, active high |
| a_oe | output | 1 | Tri-state enable for the A side pads |
| b_in | input | 9 | Data received from the B side bus (floating lines arrive as 0) |
| b_pull_low | output | 9 | Per-bit pull-low enable for the open-drain B pads |
| b_en_hi | input | 1 | B-side enable that must be high |
| b_en_lo | input | 1 | B-side enable that must be low |
| power_good | input | 1 | Supply-valid qualifier; low releases every B line |

## Verification
The embedded properties watch the timing of the storage on every cycle. An edge-capture output must not move unless a rising strobe was seen. It must carry the inverted input from the capture edge. A hold output must stay fixed while its strobe stays high, and it must show the inverted pre-rise sample when the strobe goes high. The properties also check, on every cycle, that the B lines are released under low power-good or a bad enable pair, and that the A enable passes through. Only the directed scenarios can show that each select code assigns the right element to each direction, including the asymmetric code. They also show that transparency takes effect without a clock edge, that data loaded while outputs are disabled appears once the outputs are enabled, and what the outputs read after reset.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    typedef enum logic [1:0] {
        K_PASS  = 2'd0,
        K_LATCH = 2'd1,
        K_REG   = 2'd2
    } elem_kind_e;

    localparam int SEL_W = 2;

endpackage

// File: rtl/xcvr_mode_dec.sv
module xcvr_mode_dec
    import xcvr_pkg::*;
(
    input  logic [SEL_W-1:0] mode_sel,
    output elem_kind_e       ab_kind,
    output elem_kind_e       ba_kind
);

    // bit 0 is the low select, bit 1 the high select
    always_comb begin
        case (mode_sel)
            2'b00: begin ab_kind = K_LATCH; ba_kind = K_LATCH; end
            2'b01: begin ab_kind = K_PASS;  ba_kind = K_PASS;  end
            2'b10: begin ab_kind = K_REG;   ba_kind = K_REG;   end
            default: begin ab_kind = K_REG; ba_kind = K_LATCH; end
        endcase
    end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  elem_kind_e       kind,
    input  logic             strobe,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    typedef struct packed {
        logic [WIDTH-1:0] held;
        logic             strobe_prev;
    } lane_st_t;

    lane_st_t st_d, st_q;
    logic     rise;

    always_comb begin
        st_d             = st_q;
        rise             = strobe & ~st_q.strobe_prev;
        st_d.strobe_prev = strobe;
        case (kind)
            K_LATCH: if (!strobe) st_d.held = din;
            K_REG:   if (rise)    st_d.held = din;
            default: st_d.held = st_q.held;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.held        <= '0;
            st_q.strobe_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (kind)
            K_PASS:  dout = ~din;
            K_LATCH: dout = strobe ? ~st_q.held : ~din;
            K_REG:   dout = ~st_q.held;
            default: dout = ~din;
        endcase
    end

    // edge-capture output moves only after a rising strobe
    assert_reg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && kind == K_REG && $stable(strobe))
        |=> (kind != K_REG || $stable(dout)));

    // edge-capture output carries the inverted input from the capture edge
    assert_reg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && kind == K_REG && $rose(strobe))
        |=> (kind != K_REG || dout == ~$past(din)));

    // hold stage is frozen while its strobe stays high
    assert_latch_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && kind == K_LATCH && $past(kind) == K_LATCH
         && strobe && $past(strobe))
        |-> $stable(dout));

    // on closing, hold stage shows the last transparent sample
    assert_latch_close_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && kind == K_LATCH && $past(kind) == K_LATCH && $rose(strobe))
        |-> dout == ~$past(din));

endmodule

// File: rtl/xcvr_b_drive.sv
module xcvr_b_drive #(
    parameter int WIDTH = 9
) (
    input  logic             en_hi,
    input  logic             en_lo,
    input  logic             power_good,
    input  logic [WIDTH-1:0] out_bits,
    output logic [WIDTH-1:0] pull_low
);

    logic en_hi_gated;
    logic active;

    // low supply forces the high-side enable off
    assign en_hi_gated = en_hi & power_good;
    assign active      = en_hi_gated & ~en_lo;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign pull_low[i] = active & ~out_bits[i];
    end

endmodule

// File: rtl/bus_xcvr_core.sv
module bus_xcvr_core
    import xcvr_pkg::*;
#(
    parameter int WIDTH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             cap_ab,
    input  logic             cap_ba,
    input  logic [WIDTH-1:0] a_in,
    output logic [WIDTH-1:0] a_out,
    input  logic             a_en,
    output logic             a_oe,
    input  logic [WIDTH-1:0] b_in,
    output logic [WIDTH-1:0] b_pull_low,
    input  logic             b_en_hi,
    input  logic             b_en_lo,
    input  logic             power_good
);

    elem_kind_e       ab_kind;
    elem_kind_e       ba_kind;
    logic [WIDTH-1:0] ab_out;

    xcvr_mode_dec u_dec (
        .mode_sel (mode_sel),
        .ab_kind  (ab_kind),
        .ba_kind  (ba_kind)
    );

    xcvr_lane #(.WIDTH(WIDTH)) u_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (ab_kind),
        .strobe (cap_ab),
        .din    (a_in),
        .dout   (ab_out)
    );

    xcvr_lane #(.WIDTH(WIDTH)) u_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .kind   (ba_kind),
        .strobe (cap_ba),
        .din    (b_in),
        .dout   (a_out)
    );

    xcvr_b_drive #(.WIDTH(WIDTH)) u_bdrv (
        .en_hi      (b_en_hi),
        .en_lo      (b_en_lo),
        .power_good (power_good),
        .out_bits   (ab_out),
        .pull_low   (b_pull_low)
    );

    assign a_oe = a_en;

    assert_pg_release_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !power_good |-> b_pull_low == '0);

    assert_b_enable_pair_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!b_en_hi || b_en_lo) |-> b_pull_low == '0);

    assert_a_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe == a_en);

endmodule

// File: tb/sim_bus_xcvr_core.sv
module sim_bus_xcvr_core;

    localparam int W = 9;
    localparam logic [W-1:0] X1 = 9'h1A5;
    localparam logic [W-1:0] X2 = 9'h05A;
    localparam logic [W-1:0] Y1 = 9'h133;
    localparam logic [W-1:0] Y2 = 9'h0CC;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   mode_sel = 2'b10;
    logic         cap_ab = 1'b0, cap_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic         a_en = 1'b1, b_en_hi = 1'b1, b_en_lo = 1'b0, power_good = 1'b1;
    logic [W-1:0] a_out, b_pull_low;
    logic         a_oe;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    bus_xcvr_core #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .cap_ab(cap_ab), .cap_ba(cap_ba),
        .a_in(a_in), .a_out(a_out), .a_en(a_en), .a_oe(a_oe),
        .b_in(b_in), .b_pull_low(b_pull_low),
        .b_en_hi(b_en_hi), .b_en_lo(b_en_lo), .power_good(power_good)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; mode_sel = 2'b10;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk("R13 a_out", a_out, '1);
        chk("R13 b_pull_low", b_pull_low, '0);
        chk("R8 a_oe", {{(W-1){1'b0}}, a_oe}, 9'd1);
    endtask

    task automatic t_register();
        mode_sel = 2'b10; cap_ab = 0; cap_ba = 0; a_in = X1; b_in = Y1;
        tick();
        cap_ab = 1; cap_ba = 1;
        tick();
        chk("R3 R10 capture A->B", b_pull_low, X1);
        chk("R3 R7 capture B->A", a_out, ~Y1);
        a_in = X2; b_in = Y2;
        tick(); tick();
        chk("R5 hold high A->B", b_pull_low, X1);
        chk("R5 hold high B->A", a_out, ~Y1);
        cap_ab = 0;
        tick();
        chk("R5 hold after fall", b_pull_low, X1);
        cap_ab = 1;
        tick();
        chk("R5 second rise", b_pull_low, X2);
    endtask

    task automatic t_latch();
        mode_sel = 2'b00; cap_ab = 0; cap_ba = 0; a_in = X1; b_in = Y1;
        #1;
        chk("R1 R6 transparent A->B", b_pull_low, X1);
        chk("R1 R7 transparent B->A", a_out, ~Y1);
        tick();
        cap_ab = 1; cap_ba = 1;
        #1;
        chk("R6 closed shows sample", a_out, ~Y1);
        a_in = X2; b_in = Y2;
        tick(); tick();
        chk("R6 hold A->B", b_pull_low, X1);
        chk("R6 hold B->A", a_out, ~Y1);
        cap_ba = 0;
        #1;
        chk("R6 reopen", a_out, ~Y2);
    endtask

    task automatic t_pass();
        mode_sel = 2'b01; a_in = X2; b_in = Y1;
        #1;
        chk("R2 R7 pass A->B", b_pull_low, X2);
        chk("R2 R7 pass B->A", a_out, ~Y1);
        a_in = X1; b_in = Y2;
        #1;
        chk("R2 no clock A->B", b_pull_low, X1);
        chk("R2 no clock B->A", a_out, ~Y2);
    endtask

    task automatic t_mixed();
        mode_sel = 2'b11; cap_ab = 0; cap_ba = 0; a_in = X2; b_in = Y2;
        tick();
        cap_ab = 1;
        tick();
        chk("R4 A->B register", b_pull_low, X2);
        a_in = X1;
        tick();
        chk("R4 A->B no edge", b_pull_low, X2);
        chk("R4 B->A transparent", a_out, ~Y2);
        cap_ba = 1;
        tick();
        b_in = Y1;
        tick();
        chk("R4 B->A hold", a_out, ~Y2);
    endtask

    task automatic t_enables();
        mode_sel = 2'b01; a_in = X1;
        b_en_hi = 1; b_en_lo = 0; #1;
        chk("R9 active", b_pull_low, X1);
        b_en_lo = 1; #1;
        chk("R9 hi=1 lo=1", b_pull_low, '0);
        b_en_hi = 0; b_en_lo = 0; #1;
        chk("R9 hi=0 lo=0", b_pull_low, '0);
        b_en_lo = 1; #1;
        chk("R9 hi=0 lo=1", b_pull_low, '0);
        b_en_hi = 1; b_en_lo = 0; power_good = 0; #1;
        chk("R12 power low", b_pull_low, '0);
        power_good = 1; #1;
        chk("R12 power back", b_pull_low, X1);
        a_en = 0; #1;
        chk("R8 a_oe off", {{(W-1){1'b0}}, a_oe}, 9'd0);
        a_en = 1; #1;
        chk("R8 a_oe on", {{(W-1){1'b0}}, a_oe}, 9'd1);
    endtask

    task automatic t_retain();
        mode_sel = 2'b10; b_en_hi = 0; a_en = 0;
        cap_ab = 0; cap_ba = 0; a_in = X2; b_in = Y2;
        tick();
        cap_ab = 1; cap_ba = 1;
        tick();
        chk("R11 disabled B", b_pull_low, '0);
        a_in = X1; b_in = Y1;
        tick();
        b_en_hi = 1; a_en = 1; #1;
        chk("R11 B after enable", b_pull_low, X2);
        chk("R11 A after enable", a_out, ~Y2);
    endtask

    initial begin
        t_reset();
        t_register();
        t_latch();
        t_pass();
        t_mixed();
        t_enables();
        t_retain();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule